// File: doc/BRIEF.md
# Vectored Nested Priority Interrupt Controller

This block gathers thirty-two interrupt sources and presents them to a processor on two active-low request lines: a fast request and a normal request. Each source carries an enable bit, a three-bit priority, a trigger mode and a 32-bit vector, all held in a small register window. Among the enabled normal sources the arbiter selects one winner. A processor read of the vector register acknowledges that winner and returns its vector. A write to the end-of-service register tells the block the handler has finished.

An eight-entry level stack records the priority of every acknowledged interrupt. The normal request is raised only when the best pending source outranks the level on top of the stack, so a more urgent source can interrupt a running handler. Source 0 always drives the fast line. Any other source can be steered there by its fast-steer bit. Source 1 is the OR of several system lines. A global quiet bit holds both request lines inactive, while a separate wake output still reports any pending enabled source.

Every raw input passes through a two-flop synchronizer. The block runs from one free-running clock.

Top module: `nvic_ctrl`

## Requirements
- R1: After reset `nirq_o` and `nfiq_o` are high, `wake_o` is low, and the enable register (read at offset 0x00) reads zero.
- R2: A source whose enable bit is clear never asserts a request. Writing ones to offset 0x00 sets enable bits, and writing ones to offset 0x04 clears them.
- R3: The source configuration word sits at 0x80+4n. Bits [2:0] hold the priority. Bit 4 selects edge (1) or level (0) triggering, and bit 5 inverts the polarity (falling edge or low level). Sources flagged in `EXT_MASK` honour bit 5. All other sources ignore bit 5 and are always rising or high.
- R4: An edge source latches its pending bit on a detected edge. Writing ones to 0x08 sets the latch and writing ones to 0x0C clears it. Acknowledging the source also clears it. A level source's pending bit follows its synchronized input, and the 0x08 and 0x0C writes do not affect it. The pending vector reads at 0x20.
- R5: A read at 0x14 returns the vector (stored at 0x100+4n) of the enabled normal source with the highest priority, with ties going to the lowest source number. If no request is active, the read returns the spurious vector at 0x28 and acknowledges nothing.
- R6: An acknowledge pushes the winner's priority onto the stack. `nirq_o` is asserted only while the stack is empty or the winner's priority is strictly greater than the top entry. A write to 0x18 pops one entry and is ignored when the stack is empty. Offset 0x24 reads the depth in bits [7:4] and the top level in bits [2:0].
- R7: The stack depth never exceeds eight.
- R8: Source 0 drives only `nfiq_o`. It never wins normal arbitration.
- R9: A set bit n in the fast-steer register (0x10) moves source n from `nirq_o` to `nfiq_o`.
- R10: Source 1 is level-high, whatever its mode bits say. Its input is the OR of `irq_src[1]` and all `sys_irq` lines.
- R11: Writing 1 to bit 0 of 0x1C holds both request lines high. `wake_o` still goes high while any enabled source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NSRC | Raw interrupt inputs, one per source |
| sys_irq | input | NSYS | System lines ORed into source 1 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (has side effects at 0x14) |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the cycle of `bus_rd` |
| nirq_o | output | 1 | Registered normal request, active low |
| nfiq_o | output | 1 | Registered fast request, active low |
| wake_o | output | 1 | Registered wake indication, active high |

## Verification
The hardest state to reach is a full stack: eight acknowledged interrupts, each strictly above the one before. Reaching it requires raising sources in ascending priority order and acknowledging each one before the next appears. The bench builds this ladder one source at a time. It then shows that a further read returns the spurious vector and that extra end-of-service writes leave the stack empty. Randomized rounds of priorities and input patterns then check the arbitration winner against a bench model.

// File: rtl/nvic_pkg.sv
package nvic_pkg;
  // word index of each control register (byte offset / 4)
  localparam int REG_EN_SET = 0;
  localparam int REG_EN_CLR = 1;
  localparam int REG_PN_SET = 2;
  localparam int REG_PN_CLR = 3;
  localparam int REG_FSTEER = 4;
  localparam int REG_VECTOR = 5;
  localparam int REG_EOS    = 6;
  localparam int REG_QUIET  = 7;
  localparam int REG_PEND   = 8;
  localparam int REG_NEST   = 9;
  localparam int REG_SPUR   = 10;

  // mode field: bit 0 = edge, bit 1 = inverted polarity
  typedef enum logic [1:0] {
    TRG_HIGH = 2'b00,
    TRG_RISE = 2'b01,
    TRG_LOW  = 2'b10,
    TRG_FALL = 2'b11
  } trig_e;

  function automatic logic polarity_fix(logic level, logic invert);
    return level ^ invert;
  endfunction

  function automatic logic edge_seen(logic now_lvl, logic was_lvl);
    return now_lvl & ~was_lvl;
  endfunction

  function automatic logic outranks(logic [7:0] cand, logic [7:0] top, logic empty);
    return empty || (cand > top);
  endfunction
endpackage

// File: rtl/nvic_src_cond.sv
module nvic_src_cond
  import nvic_pkg::*;
#(
  parameter int  SYNC_N      = 2,
  parameter bit  IS_EXT      = 1'b0,
  parameter bit  FORCE_LEVEL = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_in,
  input  logic [1:0] mode,
  input  logic       sw_set,
  input  logic       sw_clr,
  input  logic       ack_clr,
  output logic       pend
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              latch_q;
  logic              invert, edge_mode, cur_lvl, old_lvl, edge_hit;

  assign invert    = IS_EXT ? mode[1] : 1'b0;
  assign edge_mode = FORCE_LEVEL ? 1'b0 : mode[0];
  assign cur_lvl   = polarity_fix(sync_q[SYNC_N-1], invert);
  assign old_lvl   = polarity_fix(prev_q, invert);
  assign edge_hit  = edge_seen(cur_lvl, old_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], raw_in};
      prev_q <= sync_q[SYNC_N-1];
      if (!edge_mode)               latch_q <= 1'b0;
      else if (edge_hit || sw_set)  latch_q <= 1'b1;
      else if (sw_clr || ack_clr)   latch_q <= 1'b0;
    end
  end

  assign pend = edge_mode ? latch_q : cur_lvl;
endmodule

// File: rtl/nvic_arbiter.sv
module nvic_arbiter #(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]         cand,
  input  logic [NSRC-1:0][PW-1:0] prio,
  output logic                    win_vld,
  output logic [IW-1:0]           win_idx,
  output logic [PW-1:0]           win_prio
);
  // scan high to low index; ">=" lets lower numbers take ties
  always_comb begin
    win_vld  = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i] && (!win_vld || prio[i] >= win_prio)) begin
        win_vld  = 1'b1;
        win_idx  = IW'(i);
        win_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/nvic_level_stack.sv
module nvic_level_stack #(
  parameter int DEPTH = 8,
  parameter int PW    = 3,
  localparam int DPW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [PW-1:0]  push_lvl,
  input  logic           pop,
  output logic [DPW-1:0] depth,
  output logic [PW-1:0]  top_lvl
);
  logic [PW-1:0]  lvl_q [DEPTH];
  logic [DPW-1:0] depth_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) lvl_q[i] <= '0;
    end else if (push && depth_q < DPW'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++)
        if (depth_q == DPW'(i)) lvl_q[i] <= push_lvl;
      depth_q <= depth_q + 1'b1;
    end else if (pop && depth_q != '0) begin
      depth_q <= depth_q - 1'b1;
    end
  end

  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < DEPTH; i++)
      if (depth_q == DPW'(i + 1)) top_lvl = lvl_q[i];
  end

  assign depth = depth_q;

  p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DPW'(DEPTH));
  // R6: a push only ever stacks a strictly higher level
  p_push_strict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && depth_q != '0) |-> (push_lvl > top_lvl));
  p_push_pop_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/nvic_ctrl.sv
module nvic_ctrl
  import nvic_pkg::*;
#(
  parameter int              NSRC     = 32,
  parameter int              NPRIO    = 8,
  parameter int              NSYS     = 3,
  parameter int              DW       = 32,
  parameter int              AW       = 9,
  parameter int              SYNC_N   = 2,
  parameter logic [NSRC-1:0] EXT_MASK = 32'hF000_0001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_src,
  input  logic [NSYS-1:0] sys_irq,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            nirq_o,
  output logic            nfiq_o,
  output logic            wake_o
);
  localparam int PW       = $clog2(NPRIO);
  localparam int IW       = $clog2(NSRC);
  localparam int DPW      = $clog2(NPRIO + 1);
  localparam int WIW      = AW - 2;
  localparam int CFG_BASE = NSRC;
  localparam int VEC_BASE = 2 * NSRC;

  logic [WIW-1:0]         widx;
  logic [NSRC-1:0]        en_q, steer_q;
  logic                   quiet_q;
  logic [NSRC-1:0][PW-1:0] prio_q;
  logic [1:0]             mode_q [NSRC];
  logic [DW-1:0]          vec_q  [NSRC];
  logic [DW-1:0]          spur_q;
  logic [NSRC-1:0]        raw_vec, pend, active, norm_cand;
  logic [NSRC-1:0]        set_v, clr_v, ack_v;
  logic                   win_vld, preempt_ok, fast_any, ack_fire, eos_fire;
  logic [IW-1:0]          win_idx;
  logic [PW-1:0]          win_prio, top_lvl;
  logic [DPW-1:0]         depth;
  logic                   nirq_q, nfiq_q, wake_q;

  assign widx = bus_addr[AW-1:2];

  // raw inputs; source 1 is the OR of the system lines
  always_comb begin
    raw_vec    = irq_src;
    raw_vec[1] = irq_src[1] | (|sys_irq);
  end

  assign set_v = (bus_wr && widx == WIW'(REG_PN_SET)) ? bus_wdata[NSRC-1:0] : '0;
  assign clr_v = (bus_wr && widx == WIW'(REG_PN_CLR)) ? bus_wdata[NSRC-1:0] : '0;

  for (genvar g = 0; g < NSRC; g++) begin : gen_src
    nvic_src_cond #(
      .SYNC_N     (SYNC_N),
      .IS_EXT     (EXT_MASK[g]),
      .FORCE_LEVEL(g == 1)
    ) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_in (raw_vec[g]),
      .mode   (mode_q[g]),
      .sw_set (set_v[g]),
      .sw_clr (clr_v[g]),
      .ack_clr(ack_v[g]),
      .pend   (pend[g])
    );
  end

  assign active    = pend & en_q;
  assign norm_cand = active & ~steer_q & ~NSRC'(1);

  nvic_arbiter #(.NSRC(NSRC), .PW(PW)) u_arb (
    .cand    (norm_cand),
    .prio    (prio_q),
    .win_vld (win_vld),
    .win_idx (win_idx),
    .win_prio(win_prio)
  );

  assign preempt_ok = win_vld &&
                      outranks(8'(win_prio), 8'(top_lvl), depth == '0);
  assign fast_any   = active[0] | (|(active & steer_q));
  assign ack_fire   = bus_rd && widx == WIW'(REG_VECTOR) && preempt_ok;
  assign eos_fire   = bus_wr && widx == WIW'(REG_EOS);
  assign ack_v      = ack_fire ? (NSRC'(1) << win_idx) : '0;

  nvic_level_stack #(.DEPTH(NPRIO), .PW(PW)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (ack_fire),
    .push_lvl(win_prio),
    .pop     (eos_fire),
    .depth   (depth),
    .top_lvl (top_lvl)
  );

  // programmable state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      steer_q <= '0;
      quiet_q <= 1'b0;
      spur_q  <= '0;
      prio_q  <= '0;
      for (int i = 0; i < NSRC; i++) begin
        mode_q[i] <= TRG_HIGH;
        vec_q[i]  <= '0;
      end
    end else if (bus_wr) begin
      if (widx == WIW'(REG_EN_SET)) en_q    <= en_q | bus_wdata[NSRC-1:0];
      if (widx == WIW'(REG_EN_CLR)) en_q    <= en_q & ~bus_wdata[NSRC-1:0];
      if (widx == WIW'(REG_FSTEER)) steer_q <= bus_wdata[NSRC-1:0];
      if (widx == WIW'(REG_QUIET))  quiet_q <= bus_wdata[0];
      if (widx == WIW'(REG_SPUR))   spur_q  <= bus_wdata;
      for (int i = 0; i < NSRC; i++) begin
        if (widx == WIW'(CFG_BASE + i)) begin
          prio_q[i] <= bus_wdata[PW-1:0];
          mode_q[i] <= bus_wdata[5:4];
        end
        if (widx == WIW'(VEC_BASE + i)) vec_q[i] <= bus_wdata;
      end
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (widx)
      WIW'(REG_EN_SET), WIW'(REG_EN_CLR): bus_rdata = DW'(en_q);
      WIW'(REG_FSTEER): bus_rdata = DW'(steer_q);
      WIW'(REG_VECTOR): bus_rdata = preempt_ok ? vec_q[win_idx] : spur_q;
      WIW'(REG_QUIET):  bus_rdata = DW'(quiet_q);
      WIW'(REG_PEND):   bus_rdata = DW'(pend);
      WIW'(REG_NEST):   bus_rdata = DW'({depth, 4'(top_lvl)});
      WIW'(REG_SPUR):   bus_rdata = spur_q;
      default: begin
        for (int i = 0; i < NSRC; i++) begin
          if (widx == WIW'(CFG_BASE + i)) bus_rdata = DW'({mode_q[i], 4'(prio_q[i])});
          if (widx == WIW'(VEC_BASE + i)) bus_rdata = vec_q[i];
        end
      end
    endcase
  end

  // registered processor lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nirq_q <= 1'b1;
      nfiq_q <= 1'b1;
      wake_q <= 1'b0;
    end else begin
      nirq_q <= ~(preempt_ok & ~quiet_q);
      nfiq_q <= ~(fast_any & ~quiet_q);
      wake_q <= |active;
    end
  end

  assign nirq_o = nirq_q;
  assign nfiq_o = nfiq_q;
  assign wake_o = wake_q;

  p_src0_excluded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> (win_idx != '0));
  p_steered_not_normal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> !steer_q[win_idx]);
  p_quiet_lines_r11: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_q |=> (nirq_o && nfiq_o));
  p_wake_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|active) |=> wake_o);
endmodule

// File: tb/nvic_ctrl_tb.sv
module nvic_ctrl_tb_top;
  localparam int A_EN_SET = 'h00, A_EN_CLR = 'h04, A_PSET = 'h08, A_PCLR = 'h0C;
  localparam int A_STEER = 'h10, A_VEC = 'h14, A_EOS = 'h18, A_QUIET = 'h1C;
  localparam int A_PEND = 'h20, A_NEST = 'h24, A_SPUR = 'h28;
  localparam logic [31:0] SPUR = 32'h0BAD_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic [2:0]  sys_irq = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        nirq_o, nfiq_o, wake_o;
  int          checks = 0, failures = 0;
  int          prio_m [32];

  always #2.5 clk = ~clk;

  nvic_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .sys_irq(sys_irq),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nirq_o(nirq_o), .nfiq_o(nfiq_o), .wake_o(wake_o));

  function automatic logic [31:0] vec_of(int n);
    return 32'h4000_0000 | (32'(n) << 4);
  endfunction

  function automatic int cfg_addr(int n); return 'h80 + 4 * n; endfunction

  // bench model of the normal arbiter (no nesting, all level-high)
  function automatic int best_src(logic [31:0] req);
    int b = -1;
    for (int i = 2; i < 32; i++)
      if (req[i] && (b < 0 || prio_m[i] > prio_m[b])) b = i;
    return b;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 9'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 9'(a);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic cfg(input int n, input int prio, input logic [1:0] mode);
    wr(cfg_addr(n), {26'b0, mode, 1'b0, 3'(prio)});
    prio_m[n] = prio;
  endtask

  task automatic wipe();
    irq_src = '0; sys_irq = '0;
    wr(A_EN_CLR, '1);
    wr(A_PCLR, '1);
    settle();
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(32'(nirq_o), 1, "R1 nirq");
    chk(32'(nfiq_o), 1, "R1 nfiq");
    chk(32'(wake_o), 0, "R1 wake");
    rd(A_EN_SET, d); chk(d, 0, "R1 enable");
    for (int n = 0; n < 32; n++) wr('h100 + 4 * n, vec_of(n));
    wr(A_SPUR, SPUR);

    // R2 masking, R5 vector, R6 nesting
    cfg(5, 2, 2'b00); irq_src[5] = 1'b1; settle();
    chk(32'(nirq_o), 1, "R2 disabled quiet");
    wr(A_EN_SET, 32'h20); settle();
    chk(32'(nirq_o), 0, "R2 enabled request");
    rd(A_VEC, d); chk(d, vec_of(5), "R5 vector 5"); settle();
    chk(32'(nirq_o), 1, "R6 same level held");
    cfg(7, 4, 2'b00); irq_src[7] = 1'b1; wr(A_EN_SET, 32'h80); settle();
    chk(32'(nirq_o), 0, "R6 preempt");
    rd(A_VEC, d); chk(d, vec_of(7), "R6 vector 7");
    rd(A_NEST, d); chk(d, 32'h24, "R6 nest reg");
    cfg(9, 1, 2'b00); irq_src[9] = 1'b1; wr(A_EN_SET, 32'h200); settle();
    chk(32'(nirq_o), 1, "R6 lower blocked");
    wr(A_EOS, 0); settle();
    chk(32'(nirq_o), 0, "R6 pop reopens");
    wr(A_EOS, 0);
    rd(A_NEST, d); chk(d, 0, "R6 empty");
    wipe();
    chk(32'(nirq_o), 1, "R2 all disabled");

    // R5 tie break
    cfg(10, 3, 2'b00); cfg(12, 3, 2'b00);
    irq_src[10] = 1'b1; irq_src[12] = 1'b1;
    wr(A_EN_SET, 32'h1400); settle();
    rd(A_VEC, d); chk(d, vec_of(10), "R5 tie low index");
    wr(A_EOS, 0); wr(A_EN_CLR, 32'h400); settle();
    rd(A_VEC, d); chk(d, vec_of(12), "R5 next winner");
    wr(A_EOS, 0); wipe();

    // R4 edge latch
    cfg(14, 1, 2'b01); wr(A_EN_SET, 32'h4000);
    irq_src[14] = 1'b1; repeat (2) @(negedge clk); irq_src[14] = 1'b0; settle();
    chk(32'(nirq_o), 0, "R4 edge latched");
    rd(A_PEND, d); chk(32'(d[14]), 1, "R4 pend bit");
    rd(A_VEC, d); chk(d, vec_of(14), "R4 vector 14");
    wr(A_EOS, 0); settle();
    chk(32'(nirq_o), 1, "R4 ack cleared");
    wr(A_PSET, 32'h4000); settle();
    chk(32'(nirq_o), 0, "R4 sw set");
    wr(A_PCLR, 32'h4000); settle();
    chk(32'(nirq_o), 1, "R4 sw clear");
    cfg(5, 2, 2'b00); wr(A_EN_SET, 32'h20); wr(A_PSET, 32'h20); settle();
    rd(A_PEND, d); chk(32'(d[5]), 0, "R4 level ignores set");
    chk(32'(nirq_o), 1, "R4 level no request");
    wipe();

    // R3 polarity and modes
    irq_src[29] = 1'b1; cfg(29, 0, 2'b11); settle();
    rd(A_PEND, d); chk(32'(d[29]), 0, "R3 fall idle");
    irq_src[29] = 1'b0; settle();
    rd(A_PEND, d); chk(32'(d[29]), 1, "R3 fall latched");
    cfg(30, 0, 2'b10); settle();
    rd(A_PEND, d); chk(32'(d[30]), 1, "R3 ext low level");
    cfg(6, 0, 2'b10); settle();
    rd(A_PEND, d); chk(32'(d[6]), 0, "R3 internal ignores invert");
    irq_src[6] = 1'b1; settle();
    rd(A_PEND, d); chk(32'(d[6]), 1, "R3 internal high");
    cfg(29, 0, 2'b00); cfg(30, 0, 2'b00); cfg(6, 0, 2'b00); wipe();

    // R8 source 0
    cfg(0, 7, 2'b00); irq_src[0] = 1'b1; wr(A_EN_SET, 32'h1); settle();
    chk(32'(nfiq_o), 0, "R8 fast asserted");
    chk(32'(nirq_o), 1, "R8 normal quiet");
    rd(A_VEC, d); chk(d, SPUR, "R8 spurious");
    wipe();

    // R9 fast steering, R11 quiet
    cfg(20, 5, 2'b00); irq_src[20] = 1'b1; wr(A_EN_SET, 32'h10_0000); settle();
    chk(32'(nirq_o), 0, "R9 normal first");
    wr(A_STEER, 32'h10_0000); settle();
    chk(32'(nfiq_o), 0, "R9 steered fast");
    chk(32'(nirq_o), 1, "R9 normal dropped");
    wr(A_QUIET, 1); settle();
    chk(32'(nfiq_o), 1, "R11 fast held");
    chk(32'(wake_o), 1, "R11 wake");
    wr(A_STEER, 0); settle();
    chk(32'(nirq_o), 1, "R11 normal held");
    wr(A_QUIET, 0); settle();
    chk(32'(nirq_o), 0, "R11 released");
    wipe();
    chk(32'(wake_o), 0, "R11 wake clear");

    // R10 system source
    cfg(1, 6, 2'b01); wr(A_EN_SET, 32'h2); sys_irq = 3'b010; settle();
    chk(32'(nirq_o), 0, "R10 sys request");
    rd(A_VEC, d); chk(d, vec_of(1), "R10 vector 1");
    wr(A_EOS, 0); sys_irq = '0; settle();
    rd(A_PEND, d); chk(32'(d[1]), 0, "R10 level follows");
    wipe();

    // R7 full ladder
    for (int k = 0; k < 8; k++) begin
      cfg(16 + k, k, 2'b00); irq_src[16 + k] = 1'b1;
      wr(A_EN_SET, 32'(1) << (16 + k)); settle();
      rd(A_VEC, d); chk(d, vec_of(16 + k), "R7 ladder step");
    end
    rd(A_NEST, d); chk(d, 32'h87, "R7 full");
    rd(A_VEC, d); chk(d, SPUR, "R7 no further ack");
    rd(A_NEST, d); chk(d, 32'h87, "R7 depth held");
    for (int k = 0; k < 9; k++) wr(A_EOS, 0);
    rd(A_NEST, d); chk(d, 0, "R6 extra pop ignored");
    wipe();

    // R5 random rounds
    for (int n = 2; n < 32; n++) cfg(n, int'($urandom_range(0, 7)), 2'b00);
    wr(A_EN_SET, 32'hFFFF_FFFC);
    for (int it = 0; it < 40; it++) begin
      int exp_i;
      irq_src = $urandom() & 32'hFFFF_FFFC;
      if (it % 8 == 0) irq_src = '0;
      settle();
      exp_i = best_src(irq_src);
      chk(32'(nirq_o), (exp_i < 0) ? 1 : 0, "R5 random request");
      rd(A_VEC, d); chk(d, (exp_i < 0) ? SPUR : vec_of(exp_i), "R5 random vector");
      if (exp_i >= 0) wr(A_EOS, 0);
    end
    wipe();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule